// File: doc/BRIEF.md
# Station Address PROM Access Window

This block sits at the bottom of a network controller's 32-byte host I/O window and decides what each host access means. The lower 16 bytes hold a small writable station-address PROM; the upper 16 bytes belong to the main register port, which is reached through a forwarded-access interface. Which access shapes may touch the PROM depends on a runtime I/O width mode. Any read that fits no legal case returns all ones across the requested width. Any write that fits no legal case is dropped.

The mode is a two-state machine, `MODE_WORD` and `MODE_DWORD`. On every clock edge the machine moves to `MODE_DWORD` if `io32_in` is high and to `MODE_WORD` if it is low. It therefore makes four transitions: WORD→WORD, WORD→DWORD, DWORD→DWORD and DWORD→WORD. The PROM write-enable is registered from `prom_we_in` in the same way. Reset selects `MODE_WORD`, clears the write-enable and zeroes the PROM.

Each access is classified combinationally as PROM, forwarded or illegal. Reads return their data in the same cycle. A forwarded read completes when the register port raises `fwd_ready`.

Top module: `sapw_top`

## Requirements
- R1: After reset, all 16 PROM bytes read as zero, the mode is `MODE_WORD` and the PROM write-enable is clear. Addresses 0 to 15 select PROM byte `addr[3:0]`.
- R2: A legal PROM write changes storage only while the registered write-enable is set. Otherwise the PROM keeps its old contents.
- R3: Size codes are 0 = byte, 1 = 16-bit, 2 = 32-bit and 3 = reserved. In `MODE_WORD`, byte accesses at any PROM address and 16-bit accesses at even PROM addresses are legal; every other PROM access is illegal.
- R4: In `MODE_DWORD`, only a 32-bit access at a PROM address that is a multiple of four is legal.
- R5: PROM data is little-endian. The byte at `addr` sits on bits 7:0, `addr+1` on bits 15:8, and so on. Bits above the access width read as zero.
- R6: An illegal read returns 0x000000FF for a byte access, 0x0000FFFF for a 16-bit access and 0xFFFFFFFF for a 32-bit or reserved access.
- R7: In either mode, a 16-bit or 32-bit access at address 16 or above raises `fwd_valid` in the same cycle. It passes address, size, write flag and write data unchanged. Its read data is `fwd_rdata` masked to the access width.
- R8: An illegal access changes no PROM byte and raises no `fwd_valid`. This includes byte accesses at 16 and above and reserved sizes.
- R9: A change on `io32_in` or `prom_we_in` takes effect from the cycle after the next rising clock edge.
- R10: `acc_ready` is high for every access that is not forwarded. For a forwarded access it equals `fwd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prom_we_in | input | 1 | PROM write-enable control, registered |
| io32_in | input | 1 | 1 selects 32-bit I/O mode, registered |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 5 | Byte address within the window |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 32 | Write data, little-endian lanes |
| acc_rdata | output | 32 | Read data |
| acc_ready | output | 1 | Access completes this cycle |
| fwd_valid | output | 1 | Forwarded access strobe |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | 5 | Forwarded address |
| fwd_size | output | 2 | Forwarded size code |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_ready | input | 1 | Register port completion |
| fwd_rdata | input | 32 | Register port read data |

## Verification
The hardest case to reach from the ports is a write that is legal in shape but dropped because the write-enable is clear, or illegal in the current mode, because nothing on the outputs changes at that moment. The bench first sweeps every address and size with the write-enable clear in both modes. It then enables writes and sweeps again, tracking a byte model of the PROM. It ends by dumping all 16 bytes through byte reads in `MODE_WORD`, so any stray write shows up as a data mismatch. A separate step flips `io32_in` and issues an access in that same cycle to show that the old mode still governs it.

// File: rtl/sapw_pkg.sv
package sapw_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        MODE_WORD  = 1'b0,
        MODE_DWORD = 1'b1
    } io_mode_e;

    typedef enum logic [1:0] {
        CL_PROM    = 2'd0,
        CL_FWD     = 2'd1,
        CL_ILLEGAL = 2'd2
    } acc_class_e;

endpackage

// File: rtl/sapw_decode.sv
module sapw_decode
    import sapw_pkg::*;
#(
    parameter int AW         = 5,
    parameter int PROM_BYTES = 16,
    parameter int LANES      = 4
) (
    input  logic [AW-1:0]      addr,
    input  acc_size_e          size,
    input  io_mode_e           mode,
    output acc_class_e         cls,
    output logic [LANES-1:0]   lane_mask,
    output logic [8*LANES-1:0] width_mask
);

    logic in_prom;
    logic prom_ok;

    assign in_prom = (addr < AW'(PROM_BYTES));

    // Legality of a PROM access depends on the current I/O mode
    always_comb begin
        prom_ok = 1'b0;
        unique case (mode)
            MODE_WORD:  prom_ok = (size == SZ_BYTE) || ((size == SZ_HALF) && !addr[0]);
            MODE_DWORD: prom_ok = (size == SZ_WORD) && (addr[1:0] == 2'b00);
            default:    prom_ok = 1'b0;
        endcase
    end

    always_comb begin
        if (in_prom)
            cls = prom_ok ? CL_PROM : CL_ILLEGAL;
        else if ((size == SZ_HALF) || (size == SZ_WORD))
            cls = CL_FWD;
        else
            cls = CL_ILLEGAL;
    end

    // Byte lanes covered by the requested width
    always_comb begin
        unique case (size)
            SZ_BYTE: lane_mask = LANES'(4'b0001);
            SZ_HALF: lane_mask = LANES'(4'b0011);
            default: lane_mask = {LANES{1'b1}};
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_wmask
        assign width_mask[8*g +: 8] = {8{lane_mask[g]}};
    end

endmodule

// File: rtl/sapw_prom.sv
module sapw_prom #(
    parameter int DEPTH = 16,
    parameter int LANES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [$clog2(DEPTH)-1:0] base,
    input  logic [LANES-1:0]       lane_mask,
    input  logic [8*LANES-1:0]     wdata,
    output logic [8*LANES-1:0]     rdata
);

    localparam int IW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign idx[g] = base + IW'(g);
        assign rdata[8*g +: 8] = lane_mask[g] ? mem[idx[g]] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < DEPTH; d++) mem[d] <= 8'h00;
        end else if (wr_en) begin
            for (int l = 0; l < LANES; l++)
                if (lane_mask[l]) mem[idx[l]] <= wdata[8*l +: 8];
        end
    end

    // R5: a PROM write covers one, two or all lanes starting at lane 0
    p_lane_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (lane_mask == LANES'(4'b0001) || lane_mask == LANES'(4'b0011) ||
                   lane_mask == {LANES{1'b1}}));

    // R4: a full-width PROM write is always doubleword aligned
    p_dword_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && lane_mask == {LANES{1'b1}}) |-> (base[1:0] == 2'b00));

endmodule

// File: rtl/sapw_top.sv
module sapw_top
    import sapw_pkg::*;
#(
    parameter int PROM_BYTES = 16,
    parameter int WIN_BYTES  = 32,
    parameter int DATA_W     = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            prom_we_in,
    input  logic                            io32_in,
    input  logic                            acc_valid,
    input  logic                            acc_write,
    input  logic [$clog2(WIN_BYTES)-1:0]    acc_addr,
    input  logic [1:0]                      acc_size,
    input  logic [DATA_W-1:0]               acc_wdata,
    output logic [DATA_W-1:0]               acc_rdata,
    output logic                            acc_ready,
    output logic                            fwd_valid,
    output logic                            fwd_write,
    output logic [$clog2(WIN_BYTES)-1:0]    fwd_addr,
    output logic [1:0]                      fwd_size,
    output logic [DATA_W-1:0]               fwd_wdata,
    input  logic                            fwd_ready,
    input  logic [DATA_W-1:0]               fwd_rdata
);

    localparam int AW    = $clog2(WIN_BYTES);
    localparam int IW    = $clog2(PROM_BYTES);
    localparam int LANES = DATA_W / 8;

    io_mode_e   mode_q, mode_d;
    logic       we_q;
    acc_size_e  size_e;
    acc_class_e cls;
    logic [LANES-1:0]  lane_mask;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] prom_rdata;
    logic              prom_wr;

    assign size_e = acc_size_e'(acc_size);

    // Mode state machine: next state follows the sampled mode input
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_WORD:  if (io32_in)  mode_d = MODE_DWORD;
            MODE_DWORD: if (!io32_in) mode_d = MODE_WORD;
            default:    mode_d = MODE_WORD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_WORD;
            we_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            we_q   <= prom_we_in;
        end
    end

    sapw_decode #(.AW(AW), .PROM_BYTES(PROM_BYTES), .LANES(LANES)) u_dec (
        .addr       (acc_addr),
        .size       (size_e),
        .mode       (mode_q),
        .cls        (cls),
        .lane_mask  (lane_mask),
        .width_mask (width_mask)
    );

    assign prom_wr = acc_valid && acc_write && (cls == CL_PROM) && we_q;

    sapw_prom #(.DEPTH(PROM_BYTES), .LANES(LANES)) u_prom (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (prom_wr),
        .base      (acc_addr[IW-1:0]),
        .lane_mask (lane_mask),
        .wdata     (acc_wdata),
        .rdata     (prom_rdata)
    );

    // Output process: steer the access by its class
    always_comb begin
        fwd_valid = 1'b0;
        acc_ready = 1'b1;
        acc_rdata = width_mask;
        unique case (cls)
            CL_PROM: acc_rdata = prom_rdata;
            CL_FWD: begin
                fwd_valid = acc_valid;
                acc_ready = fwd_ready;
                acc_rdata = fwd_rdata & width_mask;
            end
            default: acc_rdata = width_mask;
        endcase
    end

    assign fwd_write = acc_write;
    assign fwd_addr  = acc_addr;
    assign fwd_size  = acc_size;
    assign fwd_wdata = acc_wdata;

    // R7: forwarding only for 16/32-bit accesses in the upper half
    p_fwd_only_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> ((acc_addr >= AW'(PROM_BYTES)) &&
                       (acc_size == 2'd1 || acc_size == 2'd2)));

    // R6: illegal reads carry ones on the low byte, zeros above a byte access
    p_ones_on_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && cls == CL_ILLEGAL) |->
            (acc_rdata[7:0] == 8'hFF &&
             (acc_size == 2'd0 ? acc_rdata[DATA_W-1:8] == '0 : acc_rdata[15:8] == 8'hFF)));

    // R8: an illegal access touches neither the PROM nor the register port
    p_illegal_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cls == CL_ILLEGAL) |-> (!fwd_valid && !prom_wr));

    // R9: mode follows the input sampled at the previous edge
    p_mode_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mode_q == ($past(io32_in) ? MODE_DWORD : MODE_WORD)));

    // R10: non-forwarded accesses always complete at once
    p_ready_local_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cls != CL_FWD) |-> acc_ready);

endmodule

// File: tb/sim_sapw_top.sv
module sim_sapw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prom_we_in = 1'b0;
    logic        io32_in = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [4:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_ready;
    logic        fwd_valid, fwd_write;
    logic [4:0]  fwd_addr;
    logic [1:0]  fwd_size;
    logic [31:0] fwd_wdata;
    logic        fwd_ready = 1'b1;
    logic [31:0] fwd_rdata;

    int checks = 0;
    int errors = 0;
    logic [7:0] model [16];

    always #5 clk = ~clk;

    sapw_top u0 (
        .clk(clk), .rst_n(rst_n), .prom_we_in(prom_we_in), .io32_in(io32_in),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .acc_ready(acc_ready), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
        .fwd_addr(fwd_addr), .fwd_size(fwd_size), .fwd_wdata(fwd_wdata),
        .fwd_ready(fwd_ready), .fwd_rdata(fwd_rdata)
    );

    function automatic logic [31:0] resp(input logic [4:0] a);
        return 32'h5A000000 ^ ({27'd0, a} * 32'h01030507);
    endfunction

    // Ideal register-port responder
    assign fwd_rdata = resp(fwd_addr);

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] ones(input logic [1:0] s);
        return (s == 2'd0) ? 32'h000000FF : (s == 2'd1) ? 32'h0000FFFF : 32'hFFFFFFFF;
    endfunction

    function automatic bit prom_legal(input bit m, input logic [4:0] a, input logic [1:0] s);
        if (a >= 16) return 0;
        if (!m) return (s == 2'd0) || (s == 2'd1 && !a[0]);
        return (s == 2'd2) && (a[1:0] == 2'b00);
    endfunction

    function automatic bit is_fwd(input logic [4:0] a, input logic [1:0] s);
        return (a >= 16) && (s == 2'd1 || s == 2'd2);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d size=%0d got=%h exp=%h", req, acc_addr, acc_size, got, exp);
        end
    endtask

    task automatic do_write(input bit m, input bit we, input logic [4:0] a,
                            input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = a; acc_size = s; acc_wdata = d;
        #1;
        if (is_fwd(a, s)) begin
            check("R7", {31'd0, fwd_valid}, 32'd1);
            check("R7", {31'd0, fwd_write}, 32'd1);
            check("R7", {27'd0, fwd_addr}, {27'd0, a});
            check("R7", {30'd0, fwd_size}, {30'd0, s});
            check("R7", fwd_wdata, d);
        end else begin
            check("R8", {31'd0, fwd_valid}, 32'd0);
            check("R10", {31'd0, acc_ready}, 32'd1);
        end
        if (prom_legal(m, a, s) && we)
            for (int i = 0; i < nbytes(s); i++) model[(a + i) % 16] = d[8*i +: 8];
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
    endtask

    task automatic do_read(input bit m, input logic [4:0] a, input logic [1:0] s);
        logic [31:0] exp;
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = a; acc_size = s;
        #1;
        if (prom_legal(m, a, s)) begin
            exp = '0;
            for (int i = 0; i < nbytes(s); i++) exp[8*i +: 8] = model[(a + i) % 16];
            check(m ? "R4" : "R3", acc_rdata, exp);
            check("R5", {31'd0, fwd_valid}, 32'd0);
        end else if (is_fwd(a, s)) begin
            check("R7", acc_rdata, resp(a) & ones(s));
            check("R10", {31'd0, acc_ready}, {31'd0, fwd_ready});
        end else begin
            check("R6", acc_rdata, ones(s));
            check("R8", {31'd0, fwd_valid}, 32'd0);
        end
        acc_valid = 0;
    endtask

    task automatic sweep(input bit m, input bit we);
        @(negedge clk);
        io32_in = m; prom_we_in = we;
        @(negedge clk);
        for (int a = 0; a < 32; a++)
            for (int s = 0; s < 4; s++) begin
                logic [31:0] d;
                d = (32'(a * 4 + s) * 32'h9E3779B9) + {30'd0, m, we} + 32'h13579BDF;
                do_write(m, we, 5'(a), 2'(s), d);
                do_read(m, 5'(a), 2'(s));
            end
    endtask

    task automatic dump(input string req);
        @(negedge clk);
        io32_in = 0;
        @(negedge clk);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            acc_valid = 1; acc_write = 0; acc_addr = 5'(a); acc_size = 2'd0;
            #1;
            check(req, acc_rdata, {24'd0, model[a]});
            acc_valid = 0;
        end
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state reads as zero in word mode
        dump("R1");
        // R2/R8: writes dropped with enable clear in both modes
        sweep(0, 0);
        sweep(1, 0);
        dump("R2");
        sweep(0, 1);
        sweep(1, 1);
        dump("R8");
        // R9: mode change applies only after the next edge
        @(negedge clk);
        io32_in = 0;
        @(negedge clk);
        io32_in = 1;
        acc_valid = 1; acc_write = 0; acc_addr = 5'd3; acc_size = 2'd0;
        #1;
        check("R9", acc_rdata, {24'd0, model[3]});
        @(negedge clk);
        #1;
        check("R9", acc_rdata, 32'h000000FF);
        acc_valid = 0;
        // R10: stalled register port stalls a forwarded access
        fwd_ready = 0;
        @(negedge clk);
        acc_valid = 1; acc_addr = 5'd20; acc_size = 2'd2;
        #1;
        check("R10", {31'd0, acc_ready}, 32'd0);
        acc_valid = 0; fwd_ready = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule